// File: doc/BRIEF.md
# UART Receive Frame Buffer with Status

This block holds received UART frames between the receive shift register and the pair of bus-readable data bytes. Two frames are buffered in arrival order. A third frame may wait in a holding stage, which models a frame sitting in the shift register. Each frame keeps up to nine data bits, plus its own frame-error and parity-error flags. The low data byte and the high status byte always show the oldest unread frame.

A bus read takes the oldest frame out of the buffer. Which byte read does this depends on the character-size mode. In nine-bit mode with the low byte read first, reading the high byte pops the frame. In every other mode, reading the low byte pops it. Software reads the non-popping byte first, so it gets both halves of the same frame.

The high byte also carries a receive-complete flag and a sticky overflow flag. Overflow is raised only in one case: the buffer is full, a frame is waiting in the holding stage, and a new start bit arrives.

Top module: `urx_frame_buffer`

## Requirements
- R1: After reset both data bytes read 0x00.
- R2: The low byte shows the low eight data bits of the oldest unread frame. Frames leave the buffer in the order they were received. When the buffer is empty, the low byte reads 0x00.
- R3: With `nine_lo_first`=1, a `rd_hi` strobe pops the oldest frame and `rd_lo` has no effect. With `nine_lo_first`=0, a `rd_lo` strobe pops and `rd_hi` has no effect. A popping strobe on an empty buffer changes nothing.
- R4: The high byte fields are:
  - bit 7: receive-complete
  - bit 6: overflow
  - bit 2: frame error
  - bit 1: parity error
  - bit 0: ninth bit
  - bits 5..3: always 0
- R5: Bit 7 of the high byte is 1 exactly when the buffer holds at least one unread frame.
- R6: Overflow (high bit 6) is set in one case only: `start_det` is high while the buffer is full, a frame waits in the holding stage, and no pop happens that cycle. Once set, it stays 1 until the next popping read, which clears it.
- R7: The frame-error bit (high bit 2) of a frame is the inverse of `frm_stop_ok` captured with that frame.
- R8: The parity-error bit (high bit 1) of a frame is 1 only if `par_en` and `frm_par_bad` were both 1 when the frame was captured.
- R9: High bit 0 depends on `lin_mode` at capture:
  - `lin_mode`=0: it is `frm_data[8]`.
  - `lin_mode`=1: it is 0 for an identifier frame (`frm_is_pid`=1) and 1 for any other frame.
- R10: A frame in the holding stage enters the buffer in the same cycle that a pop frees an entry. A push and a pop in the same cycle on a full buffer keep the order and the entry count.
- R11: A frame strobe that arrives while the holding stage is occupied and cannot move is dropped. The buffer and holding contents stay unchanged.
- R12: A frame strobed while the buffer has room is visible at the data bytes one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| nine_lo_first | input | 1 | 1: nine-bit mode with low byte read first (high byte read pops) |
| lin_mode | input | 1 | 1: LIN auto-baud receive mode, ninth bit marks the response space |
| par_en | input | 1 | Parity checking enabled |
| frm_valid | input | 1 | One-cycle strobe: a deserialized frame is complete |
| frm_data | input | 9 | Deserialized frame data |
| frm_stop_ok | input | 1 | First stop bit was sampled as 1 |
| frm_par_bad | input | 1 | Received parity did not match |
| frm_is_pid | input | 1 | Frame is the protected identifier field (LIN mode) |
| start_det | input | 1 | One-cycle strobe: a new start bit was detected |
| rd_lo | input | 1 | Bus read strobe of the low data byte |
| rd_hi | input | 1 | Bus read strobe of the high data byte |
| rd_lo_data | output | 8 | Low data byte of the oldest frame |
| rd_hi_data | output | 8 | Status byte with the ninth bit of the oldest frame |

## Verification
Most internal faults show at the data bytes one clock after the wrong edge.
- A wrong pointer or count either repeats the oldest frame, skips a frame, or drops bit 7 while frames are still held. The next pop or push then shows the fault.
- A lost holding frame appears as a missing frame two pops after an overflow.
- A wrongly selected pop byte changes the low byte after a read that should have no effect.

The bench compares both bytes on every clock against a queue-based model. Directed overflow and simultaneous push/pop scenarios put the buffer into the states where these faults appear.

// File: rtl/urxb_pkg.sv
package urxb_pkg;

  localparam int unsigned LO_W   = 8;
  localparam int unsigned DATA_W = 9;

  localparam int unsigned HI_RXC  = 7;
  localparam int unsigned HI_OVF  = 6;
  localparam int unsigned HI_FERR = 2;
  localparam int unsigned HI_PERR = 1;
  localparam int unsigned HI_NINE = 0;

  typedef struct packed {
    logic            ferr;
    logic            perr;
    logic            nine;
    logic [LO_W-1:0] lo;
  } rx_frame_t;

  function automatic logic [7:0] pack_hi(input logic rxc, input logic ovf,
                                         input rx_frame_t f);
    logic [7:0] v;
    v          = '0;
    v[HI_RXC]  = rxc;
    v[HI_OVF]  = ovf;
    v[HI_FERR] = f.ferr;
    v[HI_PERR] = f.perr;
    v[HI_NINE] = f.nine;
    return v;
  endfunction

endpackage

// File: rtl/urxb_rst_sync.sv
module urxb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/urxb_capture.sv
module urxb_capture
  import urxb_pkg::*;
(
  input  logic [DATA_W-1:0] frm_data,
  input  logic              frm_stop_ok,
  input  logic              frm_par_bad,
  input  logic              frm_is_pid,
  input  logic              par_en,
  input  logic              lin_mode,
  output rx_frame_t         frame
);
  always_comb begin
    frame.lo   = frm_data[LO_W-1:0];
    frame.ferr = ~frm_stop_ok;                 // R7
    frame.perr = par_en & frm_par_bad;         // R8
    frame.nine = lin_mode ? ~frm_is_pid        // R9
                          : frm_data[DATA_W-1];
  end
endmodule

// File: rtl/urxb_hold.sv
module urxb_hold
  import urxb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      in_v,
  input  rx_frame_t in_frame,
  input  logic      room,
  output logic      push,
  output rx_frame_t push_frame,
  output logic      hold_v
);
  logic      hv_q, hv_d;
  rx_frame_t hf_q, hf_d;
  logic      hf_en;
  logic      cand_v;

  assign cand_v     = hv_q | in_v;
  assign push       = cand_v & room;
  assign push_frame = hv_q ? hf_q : in_frame;
  assign hold_v     = hv_q;

  always_comb begin
    hv_d  = hv_q;
    hf_en = 1'b0;
    if (hv_q) begin
      if (push) begin
        hv_d  = in_v;
        hf_en = in_v;
      end
      // else: holding frame stays, any new strobe is dropped (R11)
    end else if (in_v && !push) begin
      hv_d  = 1'b1;
      hf_en = 1'b1;
    end
  end

  assign hf_d = in_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv_q <= 1'b0;
      hf_q <= '0;
    end else begin
      hv_q <= hv_d;
      if (hf_en) hf_q <= hf_d;
    end
  end

  assert_hold_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (hv_q && !push) |=> (hv_q && $stable(hf_q)));

endmodule

// File: rtl/urxb_fifo.sv
module urxb_fifo
  import urxb_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic                      pop,
  input  rx_frame_t                 wr_frame,
  output rx_frame_t                 head,
  output logic [$clog2(DEPTH+1)-1:0] cnt,
  output logic                      full,
  output logic                      nonempty
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  rx_frame_t         slot_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = push ? bump(wr_q) : wr_q;
    rd_d  = pop  ? bump(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic we;
    assign we = push && (wr_q == PTR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  slot_q[i] <= '0;
      else if (we) slot_q[i] <= wr_frame;
    end
  end

  assign head     = slot_q[rd_q];
  assign cnt      = cnt_q;
  assign full     = (cnt_q == CNT_W'(DEPTH));
  assign nonempty = (cnt_q != '0);

  assert_full_push_needs_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push) |-> pop);

  assert_pop_only_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> nonempty);

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/urxb_readout.sv
module urxb_readout
  import urxb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nine_lo_first,
  input  logic       rd_lo,
  input  logic       rd_hi,
  input  logic       start_det,
  input  logic       full,
  input  logic       nonempty,
  input  logic       hold_v,
  input  rx_frame_t  head,
  output logic       pop,
  output logic [7:0] lo_byte,
  output logic [7:0] hi_byte
);
  logic      ovf_q, ovf_d;
  logic      sel_rd;
  logic      ovf_evt;
  rx_frame_t shown;

  assign sel_rd  = nine_lo_first ? rd_hi : rd_lo;   // R3
  assign pop     = sel_rd & nonempty;
  assign ovf_evt = start_det & full & hold_v & ~pop;   // R6

  always_comb begin
    ovf_d = ovf_q;
    if (ovf_evt)  ovf_d = 1'b1;
    else if (pop) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign shown   = nonempty ? head : '0;
  assign lo_byte = shown.lo;
  assign hi_byte = pack_hi(nonempty, ovf_q, shown);

  assert_ovf_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(start_det && full && hold_v));

  assert_ovf_cleared_by_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !ovf_q);

endmodule

// File: rtl/urx_frame_buffer.sv
module urx_frame_buffer
  import urxb_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nine_lo_first,
  input  logic        lin_mode,
  input  logic        par_en,
  input  logic        frm_valid,
  input  logic [8:0]  frm_data,
  input  logic        frm_stop_ok,
  input  logic        frm_par_bad,
  input  logic        frm_is_pid,
  input  logic        start_det,
  input  logic        rd_lo,
  input  logic        rd_hi,
  output logic [7:0]  rd_lo_data,
  output logic [7:0]  rd_hi_data
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             rst_n_s;
  rx_frame_t        cap_frame, push_frame, head;
  logic             push, pop, hold_v, full, nonempty, room;
  logic [CNT_W-1:0] cnt;

  urxb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  urxb_capture u_cap (
    .frm_data(frm_data), .frm_stop_ok(frm_stop_ok), .frm_par_bad(frm_par_bad),
    .frm_is_pid(frm_is_pid), .par_en(par_en), .lin_mode(lin_mode),
    .frame(cap_frame)
  );

  assign room = ~full | pop;   // R10: a pop frees the entry in the same cycle

  urxb_hold u_hold (
    .clk(clk), .rst_n(rst_n_s), .in_v(frm_valid), .in_frame(cap_frame),
    .room(room), .push(push), .push_frame(push_frame), .hold_v(hold_v)
  );

  urxb_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n_s), .push(push), .pop(pop), .wr_frame(push_frame),
    .head(head), .cnt(cnt), .full(full), .nonempty(nonempty)
  );

  urxb_readout u_rd (
    .clk(clk), .rst_n(rst_n_s), .nine_lo_first(nine_lo_first),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .start_det(start_det), .full(full),
    .nonempty(nonempty), .hold_v(hold_v), .head(head), .pop(pop),
    .lo_byte(rd_lo_data), .hi_byte(rd_hi_data)
  );

  assert_rxc_after_push_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    push |=> rd_hi_data[HI_RXC]);

  assert_nonpop_keeps_head_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (nonempty && !pop) |=> $stable(rd_lo_data));

  assert_count_tracks_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (push && pop) |=> $stable(cnt));

endmodule

// File: tb/urx_frame_buffer_tb.sv
`timescale 1ns/1ps
module urx_frame_buffer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nine_lo_first = 0, lin_mode = 0, par_en = 0;
  logic       frm_valid = 0, frm_stop_ok = 1, frm_par_bad = 0, frm_is_pid = 0;
  logic [8:0] frm_data = '0;
  logic       start_det = 0, rd_lo = 0, rd_hi = 0;
  logic [7:0] rd_lo_data, rd_hi_data;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  urx_frame_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .nine_lo_first(nine_lo_first), .lin_mode(lin_mode),
    .par_en(par_en), .frm_valid(frm_valid), .frm_data(frm_data),
    .frm_stop_ok(frm_stop_ok), .frm_par_bad(frm_par_bad), .frm_is_pid(frm_is_pid),
    .start_det(start_det), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .rd_lo_data(rd_lo_data), .rd_hi_data(rd_hi_data)
  );

  // Behavioural reference: entry = {ferr, perr, nine, lo[7:0]}
  logic [10:0] q[$];
  logic [10:0] m_hold;
  bit          m_hv, m_ovf, m_pop, m_evt, m_pushed;
  logic [10:0] m_new;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_hv = 0; m_ovf = 0;
    end else begin
      m_new = {~frm_stop_ok, par_en & frm_par_bad,
               lin_mode ? ~frm_is_pid : frm_data[8], frm_data[7:0]};
      m_pop = (nine_lo_first ? rd_hi : rd_lo) && (q.size() > 0);
      m_evt = start_det && (q.size() == 2) && m_hv && !m_pop;
      if (m_pop) void'(q.pop_front());
      m_pushed = 0;
      if (m_hv && q.size() < 2) begin q.push_back(m_hold); m_hv = 0; m_pushed = 1; end
      if (frm_valid) begin
        if (m_hv) ;                                   // dropped
        else if (!m_pushed && q.size() < 2) q.push_back(m_new);
        else begin m_hold = m_new; m_hv = 1; end
      end
      if (m_evt) m_ovf = 1;
      else if (m_pop) m_ovf = 0;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    logic [7:0] elo, ehi;
    if (q.size() > 0) begin
      elo = q[0][7:0];
      ehi = {1'b1, m_ovf, 3'b000, q[0][10], q[0][9], q[0][8]};
    end else begin
      elo = 8'h00;
      ehi = {1'b0, m_ovf, 6'b0};
    end
    chk("R2 model low byte", rd_lo_data, elo);
    chk("R4 model high byte", rd_hi_data, ehi);
  endtask

  task automatic tick();
    @(posedge clk); #1;
    frm_valid = 0; start_det = 0; rd_lo = 0; rd_hi = 0;
    compare_model();
  endtask

  task automatic send(input logic [8:0] d, input logic stop_ok, input logic pbad,
                      input logic pid);
    frm_valid = 1; frm_data = d; frm_stop_ok = stop_ok; frm_par_bad = pbad;
    frm_is_pid = pid;
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) tick();
    chk("R1 reset low", rd_lo_data, 8'h00);
    chk("R1 reset high", rd_hi_data, 8'h00);

    // 8-bit mode: low byte read pops
    send(9'h05A, 1, 0, 0);
    chk("R12 frame visible next clock", rd_lo_data, 8'h5A);
    chk("R5 rxc set", rd_hi_data, 8'h80);
    send(9'h03C, 0, 0, 0);
    rd_hi = 1; tick();
    chk("R3 rd_hi ignored when not nine_lo_first", rd_lo_data, 8'h5A);
    rd_lo = 1; tick();
    chk("R2 second frame after pop", rd_lo_data, 8'h3C);
    chk("R7 frame error stored", rd_hi_data, 8'h84);
    rd_lo = 1; tick();
    chk("R5 rxc clear when empty", rd_hi_data, 8'h00);
    rd_lo = 1; tick();
    chk("R3 pop on empty no effect", rd_hi_data, 8'h00);

    // parity
    par_en = 1; send(9'h011, 1, 1, 0);
    chk("R8 parity error with checking on", rd_hi_data, 8'h82);
    rd_lo = 1; tick();
    par_en = 0; send(9'h022, 1, 1, 0);
    chk("R8 parity ignored with checking off", rd_hi_data, 8'h80);
    rd_lo = 1; tick();

    // 9-bit low-first mode: high byte read pops
    nine_lo_first = 1;
    send(9'h1A5, 1, 0, 0);
    chk("R9 ninth bit", rd_hi_data, 8'h81);
    rd_lo = 1; tick();
    chk("R3 rd_lo ignored in nine_lo_first", rd_lo_data, 8'hA5);
    rd_hi = 1; tick();
    chk("R3 rd_hi pops in nine_lo_first", rd_hi_data, 8'h00);
    nine_lo_first = 0;

    // LIN mode
    lin_mode = 1;
    send(9'h155, 1, 0, 1);
    chk("R9 identifier frame bit0 zero", rd_hi_data, 8'h80);
    rd_lo = 1; tick();
    send(9'h066, 1, 0, 0);
    chk("R9 response frame bit0 one", rd_hi_data, 8'h81);
    rd_lo = 1; tick();
    lin_mode = 0;

    // overflow and holding stage
    send(9'h0A1, 1, 0, 0);
    send(9'h0A2, 1, 0, 0);
    send(9'h0A3, 1, 0, 0);
    start_det = 1; tick();
    chk("R6 overflow set", rd_hi_data, 8'hC0);
    send(9'h0A4, 1, 0, 0);
    chk("R11 dropped frame keeps head", rd_lo_data, 8'hA1);
    chk("R6 overflow sticky", rd_hi_data, 8'hC0);
    rd_lo = 1; tick();
    chk("R6 overflow cleared by pop", rd_hi_data, 8'h80);
    chk("R10 order after pop", rd_lo_data, 8'hA2);
    rd_lo = 1; tick();
    chk("R10 holding frame entered on pop", rd_lo_data, 8'hA3);
    rd_lo = 1; tick();
    chk("R11 dropped frame absent", rd_hi_data, 8'h00);

    // push and pop together on a full buffer
    send(9'h0B1, 1, 0, 0);
    send(9'h0B2, 1, 0, 0);
    rd_lo = 1; send(9'h0B3, 1, 0, 0);
    chk("R10 simultaneous push/pop order", rd_lo_data, 8'hB2);
    rd_lo = 1; tick();
    chk("R10 pushed frame follows", rd_lo_data, 8'hB3);
    rd_lo = 1; tick();
    chk("R10 count consistent", rd_hi_data, 8'h00);

    // random traffic in both modes, compared each clock
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) nine_lo_first = ~nine_lo_first;
      lin_mode    = ($urandom_range(0, 9) == 0);
      par_en      = $urandom_range(0, 1);
      frm_valid   = ($urandom_range(0, 2) == 0);
      frm_data    = 9'($urandom);
      frm_stop_ok = ($urandom_range(0, 5) != 0);
      frm_par_bad = $urandom_range(0, 1);
      frm_is_pid  = $urandom_range(0, 1);
      start_det   = ($urandom_range(0, 2) == 0);
      rd_lo       = ($urandom_range(0, 3) == 0);
      rd_hi       = ($urandom_range(0, 3) == 0);
      tick();
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule